// File: doc/BRIEF.md
# Programmable CRT Raster Timing Generator

This block turns a packed eight-byte timing parameter block into the horizontal and vertical totals of a CRT raster, then runs a character counter and a line counter over that raster. Its outputs are the horizontal blank flag, the vertical sync and vertical blank flags, an active-display flag, a one-cycle frame-start pulse, and the current character and line positions. The horizontal blank and vertical blank flags are the two status bits a host polls to pace its access to display memory.

The timing fields sit at odd bit positions across the parameter bytes and are unpacked first. The two totals are then held inside the window of the selected display mode. When a total has to be moved into its window, the active count on that axis is rescaled by the ratio of the new total to the old one, so that the visible share of the line or frame is kept. The block samples the parameters and the mode once per frame, so software may rewrite them at any time.

Byte k of the parameter block is `sync_params[8k+7:8k]`. Byte 0 is not used. The word W23 is {byte 3, byte 2} and the word W67 is {byte 7, byte 6}, both little-endian.

Top module: `crt_sync_timing_gen`

## Requirements
- R1: When no clamping applies, the active character count is byte 1 plus 2.
- R2: When no clamping applies, the horizontal total in characters is the active count plus W23[4:0] (horizontal sync), plus W23[15:10] (horizontal porch), plus byte4[5:0], plus 3. Bits 7:6 of byte 4 are ignored.
- R3: The active line count is W67[9:0]. A value of 0 means 1024 lines.
- R4: Before clamping, the vertical total is the active line count plus the vertical blanking. The vertical blanking is W23[9:5] (vertical sync) plus byte5[5:0] (front porch) plus W67[15:10] (back porch), and it is forced to 1 when that sum is 0. Bits 7:6 of byte 5 are ignored.
- R5: The horizontal total is held within 104..120 when `mode_mid`=0 and within 100..112 when `mode_mid`=1. A total below the window becomes the window minimum, and a total above it becomes the window maximum.
- R6: The vertical total is held within 200..300 when `mode_mid`=0 and within 400..575 when `mode_mid`=1, using the same rule as R5.
- R7: When a total is clamped, the active count on that axis becomes floor(new total × active count / unclamped total).
- R8: `hblank` is 1 while `char_idx` is at or above the active character count. `vblank` is 1 while `line_idx` is at or above the active line count. `active` is 1 only when both blank flags are 0.
- R9: `vsync` is 1 on the lines from (active lines + byte5[5:0]) for W23[9:5] lines. Lines that would fall past the vertical total are dropped.
- R10: Parameters and mode are sampled on the first cycle after reset and at each frame wrap. A change during a frame takes effect at the start of the next frame.
- R11: `frame_start` is 1 for exactly one cycle per frame, on character 0 of line 0.
- R12: While reset is held, `char_idx` and `line_idx` are 0 and `frame_start` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_mid | input | 1 | Display mode: 0 selects the low-frequency window, 1 selects the middle window |
| sync_params | input | 64 | Eight-byte timing parameter block, byte k at bits 8k+7:8k |
| hblank | output | 1 | Character position is beyond the active character count |
| vblank | output | 1 | Line is in vertical blanking |
| vsync | output | 1 | Line is inside the vertical sync window |
| active | output | 1 | Active display area |
| frame_start | output | 1 | First cycle of line 0 |
| char_idx | output | 10 | Character position within the line |
| line_idx | output | 11 | Line position within the frame |

## Verification
The hardest case to reach from the ports is a parameter write that lands mid-frame. It must leave the running frame untouched and then take hold exactly at the wrap. A close second is a vertical sync window pushed past the end of a clamped frame, where it must vanish entirely. The stimulus rewrites the parameters and the mode ten cycles into every frame, so each measured frame runs on values the inputs no longer show. One frame uses a line field of 0, which gives 1024 lines; clamping to the low-mode maximum then rescales the active lines to 290, which places the sync window start exactly on the vertical total. Another frame sets all vertical blanking fields to zero so that the forced single blanking line appears.

// File: rtl/crt_sync_pkg.sv
package crt_sync_pkg;

  localparam int unsigned NBYTES     = 8;
  localparam int unsigned PARAM_BITS = NBYTES * 8;
  localparam int unsigned HCW        = 10;  // character counter width
  localparam int unsigned VCW        = 11;  // line counter width
  localparam int unsigned PORCHW     = 6;
  localparam int unsigned SYNCW      = 5;

  typedef struct packed {
    logic [HCW-1:0]    h_act;
    logic [HCW-1:0]    h_tot;
    logic [VCW-1:0]    v_act;
    logic [VCW-1:0]    v_tot;
    logic [PORCHW-1:0] v_front;
    logic [SYNCW-1:0]  v_sync;
  } frame_cfg_t;

  // Active count rescaled to a clamped total: floor(limit * act / tot).
  function automatic logic [31:0] rescale_active(input logic [31:0] act,
                                                 input logic [31:0] tot,
                                                 input logic [31:0] limit);
    logic [31:0] prod;
    prod = limit * act;
    return (tot == 32'd0) ? act : prod / tot;
  endfunction

endpackage

// File: rtl/crt_sync_field_unpack.sv
module crt_sync_field_unpack
  import crt_sync_pkg::*;
(
  input  logic [PARAM_BITS-1:0] sync_params,
  output logic [HCW-1:0]        h_act_raw,
  output logic [HCW-1:0]        h_tot_raw,
  output logic [VCW-1:0]        v_act_raw,
  output logic [VCW-1:0]        v_tot_raw,
  output logic [PORCHW-1:0]     v_front,
  output logic [SYNCW-1:0]      v_sync
);

  logic [7:0]     pb [NBYTES];
  logic [15:0]    hword;
  logic [15:0]    vword;
  logic [HCW-1:0] h_blank;
  logic [VCW-1:0] v_blank_sum;
  logic [VCW-1:0] v_blank;
  logic           unused_bits;

  for (genvar k = 0; k < NBYTES; k++) begin : g_bytes
    assign pb[k] = sync_params[8*k +: 8];
  end

  assign hword = {pb[3], pb[2]};
  assign vword = {pb[7], pb[6]};

  always_comb begin
    h_act_raw   = HCW'(pb[1]) + HCW'(2);
    h_blank     = HCW'(hword[4:0]) + HCW'(hword[15:10]) + HCW'(pb[4][5:0]) + HCW'(3);
    h_tot_raw   = h_act_raw + h_blank;
    v_act_raw   = (vword[9:0] == 10'd0) ? VCW'(1024) : VCW'(vword[9:0]);
    v_blank_sum = VCW'(hword[9:5]) + VCW'(pb[5][5:0]) + VCW'(vword[15:10]);
    v_blank     = (v_blank_sum == '0) ? VCW'(1) : v_blank_sum;
    v_tot_raw   = v_act_raw + v_blank;
    v_front     = pb[5][5:0];
    v_sync      = hword[9:5];
  end

  assign unused_bits = ^{pb[0], pb[4][7:6], pb[5][7:6]};

endmodule

// File: rtl/crt_sync_axis_clamp.sv
module crt_sync_axis_clamp
  import crt_sync_pkg::*;
#(
  parameter int unsigned W       = 10,
  parameter int unsigned LO_MIN  = 104,
  parameter int unsigned LO_MAX  = 120,
  parameter int unsigned MID_MIN = 100,
  parameter int unsigned MID_MAX = 112
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode_mid,
  input  logic [W-1:0] act_in,
  input  logic [W-1:0] tot_in,
  output logic [W-1:0] act_out,
  output logic [W-1:0] tot_out
);

  logic [W-1:0] lim_min;
  logic [W-1:0] lim_max;
  logic         too_small;
  logic         too_large;
  logic [W-1:0] target;

  always_comb begin
    lim_min   = mode_mid ? W'(MID_MIN) : W'(LO_MIN);
    lim_max   = mode_mid ? W'(MID_MAX) : W'(LO_MAX);
    too_small = tot_in < lim_min;
    too_large = tot_in > lim_max;
    target    = too_small ? lim_min : (too_large ? lim_max : tot_in);
    tot_out   = target;
    if (too_small || too_large)
      act_out = W'(rescale_active(32'(act_in), 32'(tot_in), 32'(target)));
    else
      act_out = act_in;
  end

  // R5 for the horizontal instance, R6 for the vertical one
  assert_total_in_window_R5_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tot_out >= lim_min) && (tot_out <= lim_max));

  // R7: a rescaled active count never exceeds the total it belongs to
  assert_scaled_fits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    act_out <= tot_out);

endmodule

// File: rtl/crt_sync_raster.sv
module crt_sync_raster
  import crt_sync_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  frame_cfg_t     cfg_next,
  output logic [HCW-1:0] char_idx,
  output logic [VCW-1:0] line_idx,
  output logic           hblank,
  output logic           vblank,
  output logic           vsync,
  output logic           active,
  output logic           frame_start
);

  localparam int unsigned VSW = VCW + 1;

  frame_cfg_t     cfg_q;
  frame_cfg_t     cfg_cur;
  logic           primed;
  logic [HCW-1:0] char_q;
  logic [VCW-1:0] line_q;
  logic           line_end;
  logic           frame_wrap;
  logic           load_cfg;
  logic [VSW-1:0] vs_begin;
  logic [VSW-1:0] vs_stop;

  assign cfg_cur    = primed ? cfg_q : cfg_next;
  assign line_end   = (char_q == cfg_cur.h_tot - HCW'(1));
  assign frame_wrap = line_end && (line_q == cfg_cur.v_tot - VCW'(1));
  assign load_cfg   = !primed || frame_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed <= 1'b0;
      cfg_q  <= '0;
      char_q <= '0;
      line_q <= '0;
    end else begin
      primed <= 1'b1;
      if (load_cfg) cfg_q <= cfg_next;
      if (line_end) begin
        char_q <= '0;
        line_q <= frame_wrap ? '0 : line_q + VCW'(1);
      end else begin
        char_q <= char_q + HCW'(1);
      end
    end
  end

  always_comb begin
    vs_begin    = VSW'(cfg_cur.v_act) + VSW'(cfg_cur.v_front);
    vs_stop     = vs_begin + VSW'(cfg_cur.v_sync);
    hblank      = char_q >= cfg_cur.h_act;
    vblank      = line_q >= cfg_cur.v_act;
    vsync       = (VSW'(line_q) >= vs_begin) && (VSW'(line_q) < vs_stop);
    active      = !hblank && !vblank;
    frame_start = (char_q == '0) && (line_q == '0);
    char_idx    = char_q;
    line_idx    = line_q;
  end

  assert_char_below_total_R2: assert property (@(posedge clk) disable iff (!rst_n)
    char_q < cfg_cur.h_tot);

  assert_line_below_total_R4: assert property (@(posedge clk) disable iff (!rst_n)
    line_q < cfg_cur.v_tot);

  assert_wrap_starts_frame_R11: assert property (@(posedge clk) disable iff (!rst_n)
    frame_wrap |=> frame_start);

  assert_cfg_held_in_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !load_cfg |=> $stable(cfg_q));

  assert_sync_inside_blank_R9: assert property (@(posedge clk) disable iff (!rst_n)
    vsync |-> vblank);

endmodule

// File: rtl/crt_sync_timing_gen.sv
module crt_sync_timing_gen
  import crt_sync_pkg::*;
#(
  parameter int unsigned LO_HMIN  = 104,
  parameter int unsigned LO_HMAX  = 120,
  parameter int unsigned LO_VMIN  = 200,
  parameter int unsigned LO_VMAX  = 300,
  parameter int unsigned MID_HMIN = 100,
  parameter int unsigned MID_HMAX = 112,
  parameter int unsigned MID_VMIN = 400,
  parameter int unsigned MID_VMAX = 575
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mode_mid,
  input  logic [PARAM_BITS-1:0] sync_params,
  output logic                  hblank,
  output logic                  vblank,
  output logic                  vsync,
  output logic                  active,
  output logic                  frame_start,
  output logic [HCW-1:0]        char_idx,
  output logic [VCW-1:0]        line_idx
);

  logic [HCW-1:0]    h_act_raw, h_tot_raw, h_act_fit, h_tot_fit;
  logic [VCW-1:0]    v_act_raw, v_tot_raw, v_act_fit, v_tot_fit;
  logic [PORCHW-1:0] v_front;
  logic [SYNCW-1:0]  v_sync;
  frame_cfg_t        cfg_next;

  crt_sync_field_unpack u_unpack (
    .sync_params (sync_params),
    .h_act_raw   (h_act_raw),
    .h_tot_raw   (h_tot_raw),
    .v_act_raw   (v_act_raw),
    .v_tot_raw   (v_tot_raw),
    .v_front     (v_front),
    .v_sync      (v_sync)
  );

  crt_sync_axis_clamp #(
    .W(HCW), .LO_MIN(LO_HMIN), .LO_MAX(LO_HMAX), .MID_MIN(MID_HMIN), .MID_MAX(MID_HMAX)
  ) u_hclamp (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_mid (mode_mid),
    .act_in   (h_act_raw),
    .tot_in   (h_tot_raw),
    .act_out  (h_act_fit),
    .tot_out  (h_tot_fit)
  );

  crt_sync_axis_clamp #(
    .W(VCW), .LO_MIN(LO_VMIN), .LO_MAX(LO_VMAX), .MID_MIN(MID_VMIN), .MID_MAX(MID_VMAX)
  ) u_vclamp (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_mid (mode_mid),
    .act_in   (v_act_raw),
    .tot_in   (v_tot_raw),
    .act_out  (v_act_fit),
    .tot_out  (v_tot_fit)
  );

  always_comb begin
    cfg_next.h_act   = h_act_fit;
    cfg_next.h_tot   = h_tot_fit;
    cfg_next.v_act   = v_act_fit;
    cfg_next.v_tot   = v_tot_fit;
    cfg_next.v_front = v_front;
    cfg_next.v_sync  = v_sync;
  end

  crt_sync_raster u_raster (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_next    (cfg_next),
    .char_idx    (char_idx),
    .line_idx    (line_idx),
    .hblank      (hblank),
    .vblank      (vblank),
    .vsync       (vsync),
    .active      (active),
    .frame_start (frame_start)
  );

endmodule

// File: tb/crt_sync_timing_gen_tb.sv
module crt_sync_timing_gen_tb;

  typedef struct {
    int hact;
    int htot;
    int vact;
    int vtot;
    int vs_first;
    int vs_count;
  } expect_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_mid = 1'b0;
  logic [63:0] sync_params = '0;
  logic        hblank, vblank, vsync, active, frame_start;
  logic [9:0]  char_idx;
  logic [10:0] line_idx;

  int n_checks = 0;
  int n_fail   = 0;
  int frames_done = 0;
  expect_t exp_q[$];

  // measurements of the frame in progress
  int  m_htot, m_hact, m_vtot, m_vact, m_vsf, m_vsc, m_bad, m_fs;
  bit  tracking = 0;

  always #2.5 clk = ~clk;

  crt_sync_timing_gen u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_mid    (mode_mid),
    .sync_params (sync_params),
    .hblank      (hblank),
    .vblank      (vblank),
    .vsync       (vsync),
    .active      (active),
    .frame_start (frame_start),
    .char_idx    (char_idx),
    .line_idx    (line_idx)
  );

  task automatic check(input string tag, input int actual, input int expected);
    n_checks++;
    if (actual !== expected) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  function automatic logic [63:0] pack(int b1, int hs, int vs, int hfp, int b4,
                                       int b5, int lfield, int vbp);
    logic [63:0] p;
    logic [15:0] w23, w67;
    w23 = {hfp[5:0], vs[4:0], hs[4:0]};
    w67 = {vbp[5:0], lfield[9:0]};
    p = {w67[15:8], w67[7:0], b5[7:0], b4[7:0], w23[15:8], w23[7:0], b1[7:0], 8'hA5};
    return p;
  endfunction

  // Expected raster from the requirement text (R1..R7, R9)
  function automatic expect_t predict(int b1, int hs, int vs, int hfp, int b4,
                                      int b5, int lfield, int vbp, bit mid);
    expect_t e;
    int hlo, hhi, vlo, vhi, vfp, blank, lines, vt, ht, ha;
    hlo = mid ? 100 : 104;  hhi = mid ? 112 : 120;
    vlo = mid ? 400 : 200;  vhi = mid ? 575 : 300;
    ha  = b1 + 2;
    ht  = ha + hs + hfp + (b4 % 64) + 3;
    if (ht < hlo)      begin ha = (hlo * ha) / ht; ht = hlo; end
    else if (ht > hhi) begin ha = (hhi * ha) / ht; ht = hhi; end
    vfp   = b5 % 64;
    lines = (lfield == 0) ? 1024 : lfield;
    blank = vs + vfp + vbp;
    if (blank == 0) blank = 1;
    vt = lines + blank;
    if (vt < vlo)      begin lines = (vlo * lines) / vt; vt = vlo; end
    else if (vt > vhi) begin lines = (vhi * lines) / vt; vt = vhi; end
    e.hact = ha;  e.htot = ht;  e.vact = lines;  e.vtot = vt;
    e.vs_first = lines + vfp;
    e.vs_count = vs;
    if (e.vs_first + e.vs_count > vt) e.vs_count = vt - e.vs_first;
    if (e.vs_count < 0) e.vs_count = 0;
    if (e.vs_count == 0) e.vs_first = -1;
    return e;
  endfunction

  // driver: present a parameter set and queue what the next frame must show
  task automatic drive(int b1, int hs, int vs, int hfp, int b4, int b5,
                       int lfield, int vbp, bit mid);
    sync_params = pack(b1, hs, vs, hfp, b4, b5, lfield, vbp);
    mode_mid    = mid;
    exp_q.push_back(predict(b1, hs, vs, hfp, b4, b5, lfield, vbp, mid));
  endtask

  task automatic wait_frame_start();
    do @(negedge clk); while (!frame_start);
  endtask

  task automatic close_frame();
    expect_t e;
    if (m_hact < 0) m_hact = m_htot;
    if (exp_q.size() == 0) begin
      check("R10 scoreboard has an expected frame", 0, 1);
      return;
    end
    e = exp_q.pop_front();
    check("R1 R7 active characters", m_hact, e.hact);
    check("R2 R5 horizontal total", m_htot, e.htot);
    check("R3 R7 active lines", m_vact, e.vact);
    check("R4 R6 vertical total", m_vtot, e.vtot);
    check("R9 vsync first line", m_vsf, e.vs_first);
    check("R9 vsync line count", m_vsc, e.vs_count);
    check("R8 active flag mismatches", m_bad, 0);
    check("R11 frame_start pulses", m_fs, 1);
    frames_done++;
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      tracking <= 0;
    end else begin
      if (frame_start) begin
        if (tracking) close_frame();
        tracking = 1;
        m_htot = 0; m_hact = -1; m_vtot = 0; m_vact = -1;
        m_vsf = -1; m_vsc = 0; m_bad = 0; m_fs = 0;
      end
      if (tracking) begin
        if (frame_start) m_fs++;
        if (line_idx == 0) begin
          if (int'(char_idx) + 1 > m_htot) m_htot = int'(char_idx) + 1;
          if (hblank && m_hact < 0) m_hact = int'(char_idx);
        end
        if (char_idx == 0) begin
          if (int'(line_idx) + 1 > m_vtot) m_vtot = int'(line_idx) + 1;
          if (vblank && m_vact < 0) m_vact = int'(line_idx);
          if (vsync) begin
            if (m_vsf < 0) m_vsf = int'(line_idx);
            m_vsc++;
          end
        end
        if (active !== (!hblank && !vblank)) m_bad++;
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check("R11 watchdog frames completed", frames_done, 4);
    finish_run();
  end

  initial begin
    // F1: low mode, inside both windows; byte 4 bits 7:6 set (ignored, R2)
    drive(78, 8, 3, 10, 8'hC5, 7, 180, 20, 1'b0);
    repeat (3) @(negedge clk);
    check("R12 char_idx in reset", int'(char_idx), 0);
    check("R12 line_idx in reset", int'(line_idx), 0);
    check("R12 frame_start in reset", int'(frame_start), 1);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (10) @(negedge clk);
    // F2: horizontal above, vertical below the low window; byte 5 bit 7 ignored (R4)
    drive(98, 10, 2, 10, 10, 8'h83, 150, 5, 1'b0);
    wait_frame_start(); repeat (10) @(negedge clk);
    // F3: 1024 lines clamped to 300, sync window pushed out of the frame
    drive(58, 4, 5, 6, 0, 10, 0, 20, 1'b0);
    wait_frame_start(); repeat (10) @(negedge clk);
    // F4: middle mode, no vertical blanking fields (forced to 1), both axes clamped
    drive(98, 0, 0, 0, 20, 0, 350, 0, 1'b1);
    wait_frame_start();
    wait_frame_start();
    repeat (5) @(negedge clk);
    check("R10 frames measured", frames_done, 4);
    finish_run();
  end

endmodule